// File: doc/BRIEF.md
# Processor Hotplug Control Register Block

This block keeps the hot-add and hot-remove bookkeeping for a fixed array of `NSLOTS` processor slots behind a small register window of three 32-bit words (12 bytes, little-endian). Each slot keeps a present bit, an insert-pending flag, a remove-pending flag, a 64-bit architecture ID and two 32-bit words written by firmware: an event source word and a status code word. Firmware selects a slot through a selector register. It then reads the slot's flags, acknowledges events, asks for an eject and issues commands. Each command also sets what the data words return.

Side-band pulse inputs per slot report a plug, an unplug request and a completed unplug. These update the flags and raise a one-cycle event interrupt. The find-next-event command starts a circular search at the current selector. The search checks one slot per clock and moves the selector to the first slot that has a pending event. While it runs, the request channel holds `req_ready` low. The block emits an eject-request pulse carrying a slot index, and a status-report pulse carrying the slot and both firmware words.

The request channel follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields steady while `req_valid` is high and `req_ready` is low. `req_ready` is low only while a search runs, which lasts at most `NSLOTS` cycles. Each accepted read returns `rsp_valid` with `rsp_rdata` exactly one cycle later. The response has no back-pressure, so the requester must take it in that cycle. Writes give no response.

Top module: `proc_hotplug_ctrl`

## Requirements
- R1: After reset the selector is 0 and the command is 0. Every flag is clear, except that slot 0 is present. No pulse output is active.
- R2: A read of word 1 returns the selected slot's state in byte lane 0: bit 0 is present, bit 1 is insert pending, bit 2 is remove pending. Every other bit reads as 0.
- R3: A write to word 1 with byte enable 0 set decodes data bits in strict priority. If bit 1 is set, the insert flag is cleared. Otherwise, if bit 2 is set, the remove flag is cleared. Otherwise, if bit 3 is set, an eject is requested.
- R4: An eject request gives a one-cycle `eject_valid` with the slot index in `eject_slot`, the cycle after the write. No pulse is given if the slot is absent or is slot 0.
- R5: A write to word 1 with byte enable 1 set loads the command from data bits 15:8. The codes are 0 = find next event, 1 = store event source, 2 = store status code, 3 = read architecture ID. A code of 4 or more leaves the previous command in place.
- R6: Command 0 checks slots one per cycle. It starts at the selector and wraps from `NSLOTS`-1 to 0. It loads the first index with an insert or remove flag into the selector, and leaves the selector unchanged if no slot has an event. `req_ready` is low for exactly the number of slots checked.
- R7: A read of word 2 returns the selector under command 0 and ID bits 31:0 under command 3. A read of word 0 returns ID bits 63:32 under command 3. All other command and word pairs return 0. The ID of slot i is `ID_BASE + i*ID_STEP`.
- R8: A write to word 2 under command 1 stores the slot's event source word. Under command 2 it stores the status code word and, the next cycle, gives a one-cycle `report_valid` with the slot, the stored source word and the new code.
- R9: When the selector is `NSLOTS` or greater, every read returns 0 and every write except to word 0 has no effect.
- R10: A pulse on `hp_plug[i]` sets present and insert pending for slot i. A pulse on `hp_unplug_req[i]` sets remove pending. A pulse on `hp_unplug_done[i]` clears present. A plug or an unplug request gives `evt_irq` high the next cycle.
- R11: If a side-band set and a register clear of the same flag fall in one cycle, the set wins. If a plug and an unplug-done of the same slot fall in one cycle, the slot stays present.
- R12: Each accepted read gives `rsp_valid` exactly one cycle later. Writes to word 0 merge only the enabled byte lanes into the selector. Word 3 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken (low during a search) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 2 | Word index: 0 selector / ID high, 1 flags and command, 2 data |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| hp_plug | input | NSLOTS | Per-slot plug pulse |
| hp_unplug_req | input | NSLOTS | Per-slot unplug request pulse |
| hp_unplug_done | input | NSLOTS | Per-slot unplug complete pulse |
| evt_irq | output | 1 | One-cycle event interrupt |
| eject_valid | output | 1 | One-cycle eject request |
| eject_slot | output | clog2(NSLOTS) | Slot to eject |
| report_valid | output | 1 | One-cycle status report |
| report_slot | output | clog2(NSLOTS) | Slot of the report |
| report_event | output | 32 | Event source word of that slot |
| report_code | output | 32 | Status code just written |

## Verification
Two functions can land in the same clock edge: a side-band plug and a firmware write to the flags byte that acknowledges the insert event of that same slot. The bench drives `hp_plug[k]` in the cycle in which the clear-insert write is taken. It then reads the flags back and expects insert pending to still be set. In the same way, it pulses plug and unplug-done of one slot together and expects the slot to stay present. Constrained random traffic mixes side-band events with register access, and a bench model predicts every read and every pulse.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    WORD_SEL  = 2'd0,
    WORD_CTRL = 2'd1,
    WORD_DATA = 2'd2,
    WORD_NONE = 2'd3
  } hp_word_e;

  typedef enum logic [1:0] {
    CMD_NEXT_EVT = 2'd0,
    CMD_SET_SRC  = 2'd1,
    CMD_SET_CODE = 2'd2,
    CMD_READ_ID  = 2'd3
  } hp_cmd_e;

  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_v,
                                                  input logic [BUS_W-1:0] new_v,
                                                  input logic [BUS_W/8-1:0] be);
    logic [BUS_W-1:0] r;
    r = old_v;
    for (int b = 0; b < BUS_W/8; b++) begin
      if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/hp_slot_bank.sv
module hp_slot_bank #(
  parameter int NSLOTS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOTS-1:0] plug,
  input  logic [NSLOTS-1:0] unplug_req,
  input  logic [NSLOTS-1:0] unplug_done,
  input  logic [NSLOTS-1:0] clr_ins,
  input  logic [NSLOTS-1:0] clr_rem,
  output logic [NSLOTS-1:0] present,
  output logic [NSLOTS-1:0] ins_pend,
  output logic [NSLOTS-1:0] rem_pend
);
  for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        present[g]  <= (g == 0);
        ins_pend[g] <= 1'b0;
        rem_pend[g] <= 1'b0;
      end else begin
        // side-band set wins over a same-cycle clear
        if (plug[g])             present[g] <= 1'b1;
        else if (unplug_done[g]) present[g] <= 1'b0;
        if (plug[g])             ins_pend[g] <= 1'b1;
        else if (clr_ins[g])     ins_pend[g] <= 1'b0;
        if (unplug_req[g])       rem_pend[g] <= 1'b1;
        else if (clr_rem[g])     rem_pend[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hp_event_scan.sv
module hp_event_scan #(
  parameter int NSLOTS = 8,
  localparam int IDX_W = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [NSLOTS-1:0] pending,
  output logic              busy,
  output logic              finish,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSLOTS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] cur_q;
  logic [IDX_W-1:0] steps_q;
  logic             last_step;

  assign busy      = busy_q;
  assign hit       = busy_q & pending[cur_q];
  assign last_step = busy_q & (steps_q == LAST);
  assign finish    = hit | last_step;
  assign hit_idx   = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      steps_q <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      cur_q   <= start_idx;
      steps_q <= '0;
    end else if (busy_q) begin
      if (finish) begin
        busy_q <= 1'b0;
      end else begin
        cur_q   <= (cur_q == LAST) ? '0 : cur_q + 1'b1;
        steps_q <= steps_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/proc_hotplug_ctrl.sv
module proc_hotplug_ctrl
  import hp_pkg::*;
#(
  parameter int          NSLOTS  = 8,
  parameter logic [63:0] ID_BASE = 64'h0000_00A0_0000_0010,
  parameter logic [63:0] ID_STEP = 64'h0000_0001_0000_0003
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [1:0]                req_word,
  input  logic [3:0]                req_be,
  input  logic [31:0]               req_wdata,
  output logic                      rsp_valid,
  output logic [31:0]               rsp_rdata,
  input  logic [NSLOTS-1:0]         hp_plug,
  input  logic [NSLOTS-1:0]         hp_unplug_req,
  input  logic [NSLOTS-1:0]         hp_unplug_done,
  output logic                      evt_irq,
  output logic                      eject_valid,
  output logic [$clog2(NSLOTS)-1:0] eject_slot,
  output logic                      report_valid,
  output logic [$clog2(NSLOTS)-1:0] report_slot,
  output logic [31:0]               report_event,
  output logic [31:0]               report_code
);
  localparam int IDX_W = $clog2(NSLOTS);

  logic [BUS_W-1:0] sel_q;
  hp_cmd_e          cmd_q;
  logic [31:0]      src_word  [NSLOTS];
  logic [31:0]      code_word [NSLOTS];
  logic [63:0]      slot_id   [NSLOTS];

  logic [NSLOTS-1:0] present, ins_pend, rem_pend;
  logic [NSLOTS-1:0] clr_ins, clr_rem;
  logic              scan_busy, scan_finish, scan_hit, scan_start;
  logic [IDX_W-1:0]  scan_idx;

  logic             accept, wr_acc, rd_acc, sel_ok, do_eject, cmd_load;
  logic [IDX_W-1:0] sel_idx;
  hp_word_e         word;
  logic [31:0]      rd_val;
  logic [31:0]      data_merged;

  for (genvar g = 0; g < NSLOTS; g++) begin : g_id
    assign slot_id[g] = ID_BASE + 64'(g) * ID_STEP;
  end

  assign word      = hp_word_e'(req_word);
  assign req_ready = ~scan_busy;
  assign accept    = req_valid & req_ready;
  assign wr_acc    = accept & req_write;
  assign rd_acc    = accept & ~req_write;
  assign sel_ok    = (sel_q < BUS_W'(NSLOTS));
  assign sel_idx   = sel_q[IDX_W-1:0];

  // flag byte decode with fixed priority, command byte load
  always_comb begin
    clr_ins  = '0;
    clr_rem  = '0;
    do_eject = 1'b0;
    if (wr_acc && word == WORD_CTRL && req_be[0] && sel_ok) begin
      if (req_wdata[1])      clr_ins[sel_idx] = 1'b1;
      else if (req_wdata[2]) clr_rem[sel_idx] = 1'b1;
      else if (req_wdata[3]) do_eject = present[sel_idx] && (sel_idx != '0);
    end
  end

  assign cmd_load   = wr_acc && word == WORD_CTRL && req_be[1] && sel_ok &&
                      (req_wdata[15:8] < 8'd4);
  assign scan_start = cmd_load && (req_wdata[9:8] == CMD_NEXT_EVT);

  hp_slot_bank #(.NSLOTS(NSLOTS)) bank_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .plug       (hp_plug),
    .unplug_req (hp_unplug_req),
    .unplug_done(hp_unplug_done),
    .clr_ins    (clr_ins),
    .clr_rem    (clr_rem),
    .present    (present),
    .ins_pend   (ins_pend),
    .rem_pend   (rem_pend)
  );

  hp_event_scan #(.NSLOTS(NSLOTS)) scan_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (scan_start),
    .start_idx(sel_idx),
    .pending  (ins_pend | rem_pend),
    .busy     (scan_busy),
    .finish   (scan_finish),
    .hit      (scan_hit),
    .hit_idx  (scan_idx)
  );

  // selector and command registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      cmd_q <= CMD_NEXT_EVT;
    end else begin
      if (wr_acc && word == WORD_SEL)
        sel_q <= lane_merge(sel_q, req_wdata, req_be);
      else if (scan_finish && scan_hit)
        sel_q <= BUS_W'(scan_idx);
      if (cmd_load) cmd_q <= hp_cmd_e'(req_wdata[9:8]);
    end
  end

  // firmware status words and report pulse
  assign data_merged = lane_merge(
      (cmd_q == CMD_SET_SRC) ? src_word[sel_idx] : code_word[sel_idx], req_wdata, req_be);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOTS; i++) begin
        src_word[i]  <= '0;
        code_word[i] <= '0;
      end
      report_valid <= 1'b0;
      report_slot  <= '0;
      report_event <= '0;
      report_code  <= '0;
    end else begin
      report_valid <= 1'b0;
      if (wr_acc && word == WORD_DATA && sel_ok) begin
        if (cmd_q == CMD_SET_SRC) begin
          src_word[sel_idx] <= data_merged;
        end else if (cmd_q == CMD_SET_CODE) begin
          code_word[sel_idx] <= data_merged;
          report_valid       <= 1'b1;
          report_slot        <= sel_idx;
          report_event       <= src_word[sel_idx];
          report_code        <= data_merged;
        end
      end
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (sel_ok) begin
      unique case (word)
        WORD_CTRL: rd_val = {29'd0, rem_pend[sel_idx], ins_pend[sel_idx], present[sel_idx]};
        WORD_DATA: begin
          if (cmd_q == CMD_NEXT_EVT)     rd_val = sel_q;
          else if (cmd_q == CMD_READ_ID) rd_val = slot_id[sel_idx][31:0];
        end
        WORD_SEL:  if (cmd_q == CMD_READ_ID) rd_val = slot_id[sel_idx][63:32];
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      evt_irq     <= 1'b0;
      eject_valid <= 1'b0;
      eject_slot  <= '0;
    end else begin
      rsp_valid   <= rd_acc;
      if (rd_acc) rsp_rdata <= rd_val;
      evt_irq     <= (|hp_plug) | (|hp_unplug_req);
      eject_valid <= do_eject;
      if (do_eject) eject_slot <= sel_idx;
    end
  end
endmodule

// File: rtl/hp_ctrl_checker.sv
module hp_ctrl_checker #(
  parameter int NSLOTS = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      req_write,
  input logic [1:0]                req_word,
  input logic                      rsp_valid,
  input logic [NSLOTS-1:0]         hp_plug,
  input logic                      evt_irq,
  input logic                      eject_valid,
  input logic [$clog2(NSLOTS)-1:0] eject_slot,
  input logic                      report_valid
);
  int unsigned stall_run;

  always_ff @(posedge clk) begin
    if (!rst_n)          stall_run <= 0;
    else if (!req_ready) stall_run <= stall_run + 1;
    else                 stall_run <= 0;
  end

  // R12: read response follows acceptance by one cycle
  a_r12_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  a_r12_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));
  // R4: slot 0 is never ejected, and ejects come only from a control-word write
  a_r4_no_boot_eject: assert property (@(posedge clk) disable iff (!rst_n)
    eject_valid |-> (eject_slot != '0));
  a_r4_eject_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    eject_valid |-> $past(req_valid && req_ready && req_write && req_word == 2'd1));
  // R8: a report follows a data-word write
  a_r8_report_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    report_valid |-> $past(req_valid && req_ready && req_write && req_word == 2'd2));
  // R10: a plug pulse raises the interrupt next cycle
  a_r10_irq_after_plug: assert property (@(posedge clk) disable iff (!rst_n)
    (|hp_plug) |=> evt_irq);
  // R6: a search never stalls the channel longer than NSLOTS cycles
  a_r6_bounded_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall_run <= NSLOTS);
endmodule

bind proc_hotplug_ctrl hp_ctrl_checker #(.NSLOTS(NSLOTS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_word    (req_word),
  .rsp_valid   (rsp_valid),
  .hp_plug     (hp_plug),
  .evt_irq     (evt_irq),
  .eject_valid (eject_valid),
  .eject_slot  (eject_slot),
  .report_valid(report_valid)
);

// File: tb/proc_hotplug_ctrl_tb_top.sv
`timescale 1ns/1ps
module proc_hotplug_ctrl_tb_top;
  localparam int          N       = 8;
  localparam int          IW      = $clog2(N);
  localparam logic [63:0] ID_BASE = 64'h0000_00A0_0000_0010;
  localparam logic [63:0] ID_STEP = 64'h0000_0001_0000_0003;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_word = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [N-1:0] hp_plug = '0, hp_unplug_req = '0, hp_unplug_done = '0;
  logic evt_irq, eject_valid, report_valid;
  logic [IW-1:0] eject_slot, report_slot;
  logic [31:0] report_event, report_code;

  always #2.5 clk = ~clk;

  proc_hotplug_ctrl #(.NSLOTS(N), .ID_BASE(ID_BASE), .ID_STEP(ID_STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .hp_plug(hp_plug),
    .hp_unplug_req(hp_unplug_req), .hp_unplug_done(hp_unplug_done), .evt_irq(evt_irq),
    .eject_valid(eject_valid), .eject_slot(eject_slot), .report_valid(report_valid),
    .report_slot(report_slot), .report_event(report_event), .report_code(report_code));

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model
  bit          m_pres[N], m_ins[N], m_rem[N];
  logic [31:0] m_src[N], m_code[N];
  logic [31:0] m_sel;
  int          m_cmd;
  int          exp_ej_cnt = 0, exp_rep_cnt = 0;
  int          exp_ej_slot = 0, exp_rep_slot = 0;
  logic [31:0] exp_rep_ev = 0, exp_rep_code = 0;

  int          ej_cnt = 0, rep_cnt = 0, ej_last = 0, rep_last = 0;
  logic [31:0] rep_ev_last = 0, rep_code_last = 0;

  always @(posedge clk) begin
    if (eject_valid) begin ej_cnt++; ej_last = int'(eject_slot); end
    if (report_valid) begin
      rep_cnt++; rep_last = int'(report_slot);
      rep_ev_last = report_event; rep_code_last = report_code;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] id_of(input int i);
    return ID_BASE + 64'(i) * ID_STEP;
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] w);
    int s;
    if (m_sel >= 32'(N)) return 32'd0;
    s = int'(m_sel);
    case (w)
      2'd1: return {29'd0, m_rem[s], m_ins[s], m_pres[s]};
      2'd2: return (m_cmd == 0) ? m_sel : (m_cmd == 3) ? id_of(s)[31:0] : 32'd0;
      2'd0: return (m_cmd == 3) ? id_of(s)[63:32] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  task automatic model_write(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    int s;
    if (w == 2'd0) begin m_sel = merge(m_sel, d, be); return; end
    if (m_sel >= 32'(N)) return;
    s = int'(m_sel);
    if (w == 2'd1) begin
      if (be[0]) begin
        if (d[1]) m_ins[s] = 0;
        else if (d[2]) m_rem[s] = 0;
        else if (d[3] && m_pres[s] && s != 0) begin exp_ej_cnt++; exp_ej_slot = s; end
      end
      if (be[1] && d[15:8] < 8'd4) begin
        m_cmd = int'(d[9:8]);
        if (m_cmd == 0) begin
          for (int k = 0; k < N; k++) begin
            int i = (s + k) % N;
            if (m_ins[i] || m_rem[i]) begin m_sel = 32'(i); break; end
          end
        end
      end
    end else if (w == 2'd2) begin
      if (m_cmd == 1) m_src[s] = merge(m_src[s], d, be);
      else if (m_cmd == 2) begin
        m_code[s] = merge(m_code[s], d, be);
        exp_rep_cnt++; exp_rep_slot = s; exp_rep_ev = m_src[s]; exp_rep_code = m_code[s];
      end
    end
  endtask

  task automatic xfer(input bit wr, input logic [1:0] w, input logic [3:0] be,
                      input logic [31:0] d, output logic [31:0] rd, output bit rv);
    req_valid = 1; req_write = wr; req_word = w; req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd = rsp_rdata; rv = rsp_valid;
  endtask

  task automatic bus_write(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] rd; bit rv;
    xfer(1, w, be, d, rd, rv);
    model_write(w, be, d);
  endtask

  task automatic bus_read(input logic [1:0] w, input string tag);
    logic [31:0] rd, e; bit rv;
    e = exp_read(w);
    xfer(0, w, 4'hF, 32'd0, rd, rv);
    chk(rv, {tag, " R12 rsp_valid"}, 64'(rv), 64'd1);
    chk(rd == e, tag, 64'(rd), 64'(e));
  endtask

  task automatic check_pulses(input string tag);
    @(negedge clk);
    chk(ej_cnt == exp_ej_cnt, {tag, " R4 eject count"}, 64'(ej_cnt), 64'(exp_ej_cnt));
    if (exp_ej_cnt > 0) chk(ej_last == exp_ej_slot, {tag, " R4 eject slot"}, 64'(ej_last), 64'(exp_ej_slot));
    chk(rep_cnt == exp_rep_cnt, {tag, " R8 report count"}, 64'(rep_cnt), 64'(exp_rep_cnt));
    if (exp_rep_cnt > 0) begin
      chk(rep_last == exp_rep_slot, {tag, " R8 report slot"}, 64'(rep_last), 64'(exp_rep_slot));
      chk(rep_ev_last == exp_rep_ev, {tag, " R8 report event"}, 64'(rep_ev_last), 64'(exp_rep_ev));
      chk(rep_code_last == exp_rep_code, {tag, " R8 report code"}, 64'(rep_code_last), 64'(exp_rep_code));
    end
  endtask

  // kind 0 plug, 1 unplug request, 2 unplug done
  task automatic side(input int kind, input int s);
    while (!req_ready) @(negedge clk);
    case (kind)
      0: hp_plug[s] = 1'b1;
      1: hp_unplug_req[s] = 1'b1;
      default: hp_unplug_done[s] = 1'b1;
    endcase
    @(negedge clk);
    hp_plug = '0; hp_unplug_req = '0; hp_unplug_done = '0;
    chk(evt_irq == (kind != 2), "R10 evt_irq after side-band", 64'(evt_irq), 64'(kind != 2));
    case (kind)
      0: begin m_pres[s] = 1; m_ins[s] = 1; end
      1: m_rem[s] = 1;
      default: m_pres[s] = 0;
    endcase
  endtask

  task automatic set_sel(input int s);
    bus_write(2'd0, 4'hF, 32'(s));
  endtask

  task automatic timed_scan(input int exp_cycles, input int exp_sel);
    int low = 0;
    bus_write(2'd1, 4'b0010, 32'h0000_0000);
    while (!req_ready) begin low++; @(negedge clk); end
    chk(low == exp_cycles, "R6 search stall length", 64'(low), 64'(exp_cycles));
    chk(m_sel == 32'(exp_sel), "R6 model selector after search", 64'(m_sel), 64'(exp_sel));
    bus_read(2'd2, "R6 selector after search");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired R12 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_pres[i] = (i == 0); m_ins[i] = 0; m_rem[i] = 0; m_src[i] = 0; m_code[i] = 0;
    end
    m_sel = 0; m_cmd = 0;
    void'($urandom(32'h1d0c_5eed));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(req_ready && !evt_irq && !eject_valid && !report_valid, "R1 idle outputs after reset",
        64'({req_ready, evt_irq, eject_valid, report_valid}), 64'h8);
    bus_read(2'd1, "R1 slot0 present after reset");
    bus_read(2'd2, "R1 selector zero under command 0");
    set_sel(5);
    bus_read(2'd1, "R1 slot5 flags clear");

    // R7 ID reads
    bus_write(2'd1, 4'b0010, 32'h0000_0300);
    bus_read(2'd2, "R7 ID low");
    bus_read(2'd0, "R7 ID high");
    // R5 illegal command leaves previous
    bus_write(2'd1, 4'b0010, 32'h0000_0500);
    bus_read(2'd2, "R5 illegal code keeps command 3");
    bus_read(2'd3, "R12 word 3 reads zero");

    // R10 side-band, R2 flags format
    side(0, 5);
    bus_read(2'd1, "R2 R10 plug sets present+insert");
    side(1, 5);
    bus_read(2'd1, "R2 R10 unplug request sets remove");
    // R3 priority: bits 1 and 2 and 3 -> only insert cleared
    bus_write(2'd1, 4'b0001, 32'h0000_000E);
    check_pulses("R3 clear insert has priority");
    bus_read(2'd1, "R3 insert cleared, remove kept");
    bus_write(2'd1, 4'b0001, 32'h0000_000C);
    check_pulses("R3 clear remove over eject");
    bus_read(2'd1, "R3 remove cleared");
    bus_write(2'd1, 4'b0001, 32'h0000_0008);
    check_pulses("R4 eject of present slot 5");
    side(2, 5);
    bus_read(2'd1, "R10 unplug done clears present");
    bus_write(2'd1, 4'b0001, 32'h0000_0008);
    check_pulses("R4 eject of absent slot ignored");
    set_sel(0);
    bus_write(2'd1, 4'b0001, 32'h0000_0008);
    check_pulses("R4 eject of slot 0 ignored");

    // R6 searches
    timed_scan(N, 0);
    side(0, 2);
    set_sel(6);
    timed_scan(5, 2);
    timed_scan(1, 2);
    bus_write(2'd1, 4'b0001, 32'h0000_0002);
    side(1, 7);
    set_sel(7);
    timed_scan(1, 7);
    bus_write(2'd1, 4'b0001, 32'h0000_0004);

    // R8 status words
    set_sel(3);
    bus_write(2'd1, 4'b0010, 32'h0000_0100);
    bus_write(2'd2, 4'hF, 32'hCAFE_0103);
    check_pulses("R8 source write gives no report");
    bus_write(2'd1, 4'b0010, 32'h0000_0200);
    bus_write(2'd2, 4'hF, 32'h0000_0042);
    check_pulses("R8 code write report");
    bus_read(2'd2, "R7 data reads zero under command 2");

    // R9 and R12 selector byte lanes
    bus_write(2'd0, 4'b0010, 32'h0000_0100);
    bus_read(2'd1, "R9 R12 partial selector write out of range");
    bus_write(2'd1, 4'b0001, 32'h0000_0008);
    bus_write(2'd1, 4'b0010, 32'h0000_0300);
    bus_write(2'd2, 4'hF, 32'h1234_5678);
    check_pulses("R9 writes ignored out of range");
    bus_write(2'd0, 4'b0010, 32'h0000_0000);
    bus_read(2'd2, "R9 command unchanged, back in range");

    // R11 same-cycle collisions
    side(0, 4);
    set_sel(4);
    while (!req_ready) @(negedge clk);
    hp_plug[4] = 1'b1;
    bus_write(2'd1, 4'b0001, 32'h0000_0002);
    hp_plug = '0;
    m_ins[4] = 1; m_pres[4] = 1;
    bus_read(2'd1, "R11 plug wins over clear-insert");
    hp_plug[4] = 1'b1; hp_unplug_done[4] = 1'b1;
    @(negedge clk);
    hp_plug = '0; hp_unplug_done = '0;
    bus_read(2'd1, "R11 plug wins over unplug done");

    // constrained random
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 8);
      case (op)
        0: side(int'($urandom % 3), int'($urandom % N));
        1: set_sel(int'($urandom % (N + 2)));
        2: bus_write(2'd1, 4'b0001, 32'($urandom % 16));
        3: bus_write(2'd1, 4'b0010, 32'($urandom % 6) << 8);
        4: bus_write(2'd2, 4'hF, $urandom);
        5: bus_read(2'd1, "R2 random flags read");
        6: bus_read(2'd2, "R7 random data read");
        default: bus_read(2'd0, "R7 random high read");
      endcase
      if (it % 50 == 49) check_pulses("R4 R8 random pulses");
    end
    while (!req_ready) @(negedge clk);
    check_pulses("R4 R8 final pulses");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule